// File: doc/BRIEF.md
# Strided Banked Vector Memory Port

This block turns a single vector memory request into a stream of element accesses against an array of independently addressed memory banks. A request carries a base word address, an element stride, an element count and a direction (load or store). In indexed mode the stride is replaced by a vector of per-element offsets, so the same port performs gathers (loads) and scatters (stores). Every element is mapped to a bank by its word address, and that bank alone receives an enable and a row address in that cycle.

Each bank keeps a busy timer after it is touched. When the next element in order maps to a bank whose timer has not expired, element issue stalls until it has. Without conflicts the port issues one element per clock. Load data comes back from the banks after a fixed latency and leaves the port in element order, tagged with its element index and a last flag. A one-cycle completion pulse closes every request.

Top module: `vmp_port`

## Requirements
- R1: After reset `req_ready` is 1 and `bank_en`, `ld_valid` and `done` are 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 up to and including the `done` cycle, and returns to 1 in the next cycle.
- R3: For a word address A, the bank is A mod NB and the row is A / NB (`bank_row` field b sits at bits [b*RW +: RW]). At most one bit of `bank_en` is set in any cycle.
- R4: In strided mode element i uses address (base + i*stride) mod 2^AW. The stride is an AW-bit two's complement value, so negative strides and wrap-around are legal.
- R5: In indexed mode element i uses address (base + index[i]) mod 2^AW, where index[i] is `req_index[i*AW +: AW]`. A load gathers and a store scatters.
- R6: After a bank is accessed in cycle t, it is not accessed again before cycle t+BUSY. Elements issue strictly in order, and issue stalls while the next element's bank is busy.
- R7: With no busy bank in the way, one element issues per cycle, and the first element can issue in the cycle after acceptance.
- R8: The data for a load element accessed in cycle t leaves on `ld_data` in cycle t+LAT with `ld_valid`. `ld_idx` gives the element number, the elements leave in order, and `ld_last` marks the final element.
- R9: A store element i drives `bank_we` together with `bank_en` on its bank and puts `req_wdata[i*DW +: DW]` on `bank_wdata`. A store produces no `ld_valid`.
- R10: `done` is a one-cycle pulse. For a store it comes in the cycle after the final element access. For a load it comes in the cycle after the final `ld_valid`.
- R11: A stride of zero hits one bank, so element k issues exactly k*BUSY cycles after element 0 when that bank starts idle.
- R12: A request with count 0 touches no bank, and `done` pulses in the cycle after acceptance.
- R13: Bank timers keep running across requests, so a new request's first element waits for a bank left busy by the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Port idle and able to take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_indexed | input | 1 | 1 = use the offset vector, 0 = use the stride |
| req_base | input | AW | Base word address |
| req_stride | input | AW | Element stride in words, two's complement |
| req_count | input | CW | Number of elements, 0 to MAXN |
| req_index | input | MAXN*AW | Per-element offsets for indexed mode |
| req_wdata | input | MAXN*DW | Per-element store data |
| bank_en | output | NB | Per-bank access enable |
| bank_we | output | NB | Per-bank write enable |
| bank_row | output | NB*RW | Per-bank row address |
| bank_wdata | output | DW | Store data for the enabled bank |
| bank_rdata | input | NB*DW | Per-bank read data, LAT cycles after access |
| ld_valid | output | 1 | Load element valid |
| ld_data | output | DW | Load element data |
| ld_idx | output | EW | Load element number |
| ld_last | output | 1 | Final load element |
| done | output | 1 | Request complete pulse |

## Verification
A unit-stride load over more elements than there are banks shows that full-rate issue holds when each bank is revisited only after its busy time. Strides equal to the bank count and to half of it, and a stride of zero, produce repeated hits at different spacings, so issue cycles separate a missing stall, a stall that is too short and a stall that is too long. Negative and wrapping strides and indexed accesses with repeated banks check the address arithmetic and the bank mapping. Each store is read back by a later load, and back-to-back requests to one bank show whether the timers carry over between requests.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
   typedef enum logic [1:0] {
      VMP_IDLE  = 2'd0,
      VMP_ISSUE = 2'd1,
      VMP_DRAIN = 2'd2,
      VMP_FIN   = 2'd3
   } vmp_state_e;
endpackage

// File: rtl/vmp_agu.sv
module vmp_agu #(
   parameter int AW          = 10,
   parameter int MAXN        = 16,
   parameter int HAS_INDEXED = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         step,
   input  logic [AW-1:0]                in_base,
   input  logic [AW-1:0]                in_stride,
   input  logic                         in_indexed,
   input  logic [MAXN*AW-1:0]           in_index,
   input  logic [$clog2(MAXN+1)-1:0]    in_count,
   output logic [AW-1:0]                addr,
   output logic [$clog2(MAXN)-1:0]      elem,
   output logic                         last_elem
);
   localparam int EW = $clog2(MAXN);
   localparam int CW = $clog2(MAXN+1);

   logic [AW-1:0] base_q, acc_q, stride_q;
   logic [EW-1:0] elem_q;
   logic [CW-1:0] cnt_q;

   // running strided address and element counter
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         acc_q    <= '0;
         stride_q <= '0;
         elem_q   <= '0;
         cnt_q    <= '0;
      end else if (start) begin
         base_q   <= in_base;
         acc_q    <= in_base;
         stride_q <= in_stride;
         elem_q   <= '0;
         cnt_q    <= in_count;
      end else if (step) begin
         elem_q   <= elem_q + EW'(1);
         acc_q    <= acc_q + stride_q;
      end
   end

   assign elem      = elem_q;
   assign last_elem = (CW'(elem_q) + CW'(1)) == cnt_q;

   generate
      if (HAS_INDEXED != 0) begin : g_indexed
         logic               idx_mode_q;
         logic [MAXN*AW-1:0] idx_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               idx_mode_q <= 1'b0;
               idx_q      <= '0;
            end else if (start) begin
               idx_mode_q <= in_indexed;
               idx_q      <= in_index;
            end
         end
         assign addr = idx_mode_q ? (base_q + idx_q[elem_q*AW +: AW]) : acc_q;
      end else begin : g_strided_only
         logic unused_idx;
         assign unused_idx = ^{in_indexed, in_index, base_q};
         assign addr = acc_q;
      end
   endgenerate
endmodule

// File: rtl/vmp_bank_timers.sv
module vmp_bank_timers #(
   parameter int NB   = 8,
   parameter int BUSY = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] hit,
   output logic [NB-1:0] busy
);
   localparam int TW = (BUSY > 1) ? $clog2(BUSY) : 1;

   generate
      if (BUSY <= 1) begin : g_no_busy
         logic unused_hit;
         assign unused_hit = ^hit;
         assign busy = '0;
      end else begin : g_timed
         for (genvar b = 0; b < NB; b++) begin : g_bank
            logic [TW-1:0] cnt_q;
            // reload on access, count down to zero, bank free at zero
            always_ff @(posedge clk) begin
               if (!rst_n)               cnt_q <= '0;
               else if (hit[b])          cnt_q <= TW'(BUSY - 1);
               else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
            end
            assign busy[b] = (cnt_q != '0);

            assert_busy_bank_untouched_R6: assert property (
               @(posedge clk) disable iff (!rst_n) hit[b] |-> !busy[b]);
         end
      end
   endgenerate
endmodule

// File: rtl/vmp_ret_pipe.sv
module vmp_ret_pipe #(
   parameter int LAT = 12,
   parameter int LB  = 3,
   parameter int EW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [LB-1:0] in_bank,
   input  logic [EW-1:0] in_idx,
   input  logic          in_last,
   output logic          out_valid,
   output logic [LB-1:0] out_bank,
   output logic [EW-1:0] out_idx,
   output logic          out_last
);
   typedef struct packed {
      logic          v;
      logic [LB-1:0] b;
      logic [EW-1:0] i;
      logic          l;
   } tag_t;

   tag_t stg_q [LAT];

   // fixed-latency tag line, aligned with the bank read latency
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < LAT; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= '{v: in_valid, b: in_bank, i: in_idx, l: in_last};
         for (int s = 1; s < LAT; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign out_valid = stg_q[LAT-1].v;
   assign out_bank  = stg_q[LAT-1].b;
   assign out_idx   = stg_q[LAT-1].i;
   assign out_last  = stg_q[LAT-1].l;
endmodule

// File: rtl/vmp_port.sv
module vmp_port
   import vmp_pkg::*;
#(
   parameter int AW          = 10,
   parameter int DW          = 16,
   parameter int NB          = 8,
   parameter int BUSY        = 4,
   parameter int LAT         = 12,
   parameter int MAXN        = 16,
   parameter int HAS_INDEXED = 1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   output logic                                   req_ready,
   input  logic                                   req_store,
   input  logic                                   req_indexed,
   input  logic [AW-1:0]                          req_base,
   input  logic [AW-1:0]                          req_stride,
   input  logic [$clog2(MAXN+1)-1:0]              req_count,
   input  logic [MAXN*AW-1:0]                     req_index,
   input  logic [MAXN*DW-1:0]                     req_wdata,
   output logic [NB-1:0]                          bank_en,
   output logic [NB-1:0]                          bank_we,
   output logic [NB*(AW-$clog2(NB))-1:0]          bank_row,
   output logic [DW-1:0]                          bank_wdata,
   input  logic [NB*DW-1:0]                       bank_rdata,
   output logic                                   ld_valid,
   output logic [DW-1:0]                          ld_data,
   output logic [$clog2(MAXN)-1:0]                ld_idx,
   output logic                                   ld_last,
   output logic                                   done
);
   localparam int LB = $clog2(NB);
   localparam int RW = AW - LB;
   localparam int EW = $clog2(MAXN);

   // elaboration-time parameter checks
   generate
      if ((1 << LB) != NB || NB < 2) begin : g_bad_nb
         $error("vmp_port: NB must be a power of two of at least 2");
      end
      if (BUSY < 1) begin : g_bad_busy
         $error("vmp_port: BUSY must be at least 1");
      end
      if (LAT < 1) begin : g_bad_lat
         $error("vmp_port: LAT must be at least 1");
      end
      if (MAXN < 2) begin : g_bad_maxn
         $error("vmp_port: MAXN must be at least 2");
      end
      if (AW <= LB) begin : g_bad_aw
         $error("vmp_port: AW must exceed log2(NB)");
      end
   endgenerate

   vmp_state_e         state_q;
   logic               store_q;
   logic [MAXN*DW-1:0] wdata_q;

   logic [AW-1:0] addr;
   logic [EW-1:0] elem;
   logic          last_elem;
   logic [NB-1:0] busy;
   logic [LB-1:0] cur_bank;
   logic [RW-1:0] cur_row;
   logic          start, fire;

   logic          ret_v, ret_last;
   logic [LB-1:0] ret_bank;
   logic [EW-1:0] ret_idx;

   assign start    = (state_q == VMP_IDLE) && req_valid;
   assign cur_bank = addr[LB-1:0];
   assign cur_row  = addr[AW-1:LB];
   assign fire     = (state_q == VMP_ISSUE) && !busy[cur_bank];

   vmp_agu #(.AW(AW), .MAXN(MAXN), .HAS_INDEXED(HAS_INDEXED)) u_agu (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .step       (fire),
      .in_base    (req_base),
      .in_stride  (req_stride),
      .in_indexed (req_indexed),
      .in_index   (req_index),
      .in_count   (req_count),
      .addr       (addr),
      .elem       (elem),
      .last_elem  (last_elem)
   );

   vmp_bank_timers #(.NB(NB), .BUSY(BUSY)) u_timers (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (bank_en),
      .busy  (busy)
   );

   vmp_ret_pipe #(.LAT(LAT), .LB(LB), .EW(EW)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (fire && !store_q),
      .in_bank   (cur_bank),
      .in_idx    (elem),
      .in_last   (last_elem),
      .out_valid (ret_v),
      .out_bank  (ret_bank),
      .out_idx   (ret_idx),
      .out_last  (ret_last)
   );

   // per-bank address and enables
   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank_if
         assign bank_en[b]             = fire && (cur_bank == LB'(b));
         assign bank_we[b]             = bank_en[b] && store_q;
         assign bank_row[b*RW +: RW]   = bank_en[b] ? cur_row : '0;
      end
   endgenerate

   assign bank_wdata = store_q ? wdata_q[elem*DW +: DW] : '0;

   // request sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= VMP_IDLE;
         store_q <= 1'b0;
         wdata_q <= '0;
      end else begin
         case (state_q)
            VMP_IDLE: if (req_valid) begin
               store_q <= req_store;
               wdata_q <= req_wdata;
               state_q <= (req_count == '0) ? VMP_FIN : VMP_ISSUE;
            end
            VMP_ISSUE: if (fire && last_elem) begin
               state_q <= store_q ? VMP_FIN : VMP_DRAIN;
            end
            VMP_DRAIN: if (ret_v && ret_last) begin
               state_q <= VMP_FIN;
            end
            default: state_q <= VMP_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == VMP_IDLE);
   assign done      = (state_q == VMP_FIN);
   assign ld_valid  = ret_v;
   assign ld_data   = ret_v ? bank_rdata[ret_bank*DW +: DW] : '0;
   assign ld_idx    = ret_idx;
   assign ld_last   = ret_v && ret_last;

   // returned-element counter used only by the ordering check
   logic [EW-1:0] ld_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        ld_cnt_q <= '0;
      else if (start)    ld_cnt_q <= '0;
      else if (ld_valid) ld_cnt_q <= ld_cnt_q + EW'(1);
   end

   assert_one_bank_R3: assert property (
      @(posedge clk) disable iff (!rst_n) $onehot0(bank_en));

   assert_load_order_R8: assert property (
      @(posedge clk) disable iff (!rst_n) ld_valid |-> (ld_idx == ld_cnt_q));

   assert_ready_after_done_R10: assert property (
      @(posedge clk) disable iff (!rst_n) done |=> req_ready);

   assert_quiet_when_idle_R2: assert property (
      @(posedge clk) disable iff (!rst_n) req_ready |-> (bank_en == '0 && !ld_valid));
endmodule

// File: tb/vmp_port_tb.sv
module vmp_port_tb;
   localparam int AW   = 10;
   localparam int DW   = 16;
   localparam int NB   = 8;
   localparam int BUSY = 4;
   localparam int LAT  = 12;
   localparam int MAXN = 16;
   localparam int LB   = $clog2(NB);
   localparam int RW   = AW - LB;
   localparam int CW   = $clog2(MAXN+1);
   localparam int EW   = $clog2(MAXN);
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n;
   logic               req_valid, req_ready, req_store, req_indexed;
   logic [AW-1:0]      req_base, req_stride;
   logic [CW-1:0]      req_count;
   logic [MAXN*AW-1:0] req_index;
   logic [MAXN*DW-1:0] req_wdata;
   logic [NB-1:0]      bank_en, bank_we;
   logic [NB*RW-1:0]   bank_row;
   logic [DW-1:0]      bank_wdata;
   logic [NB*DW-1:0]   bank_rdata;
   logic               ld_valid, ld_last, done;
   logic [DW-1:0]      ld_data;
   logic [EW-1:0]      ld_idx;

   vmp_port #(.AW(AW), .DW(DW), .NB(NB), .BUSY(BUSY), .LAT(LAT), .MAXN(MAXN), .HAS_INDEXED(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_store(req_store), .req_indexed(req_indexed), .req_base(req_base),
      .req_stride(req_stride), .req_count(req_count), .req_index(req_index),
      .req_wdata(req_wdata), .bank_en(bank_en), .bank_we(bank_we), .bank_row(bank_row),
      .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .ld_valid(ld_valid),
      .ld_data(ld_data), .ld_idx(ld_idx), .ld_last(ld_last), .done(done)
   );

   int     n_cmp = 0, n_bad = 0;
   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(a * 173 + 29) ^ 16'h3c5a;
   endfunction

   function automatic longint lmax(input longint a, input longint b);
      return (a > b) ? a : b;
   endfunction

   // behavioural bank array with fixed read latency
   logic [DW-1:0] mem    [WORDS];
   logic [DW-1:0] shadow [WORDS];
   logic          dl_v [LAT];
   logic [LB-1:0] dl_b [LAT];
   logic [DW-1:0] dl_d [LAT];

   initial begin
      for (int a = 0; a < WORDS; a++) begin
         mem[a]    = pat(a);
         shadow[a] = pat(a);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < LAT; s++) dl_v[s] <= 1'b0;
      end else begin
         for (int s = LAT-1; s > 0; s--) begin
            dl_v[s] <= dl_v[s-1];
            dl_b[s] <= dl_b[s-1];
            dl_d[s] <= dl_d[s-1];
         end
         dl_v[0] <= 1'b0;
         for (int b = 0; b < NB; b++) begin
            if (bank_en[b]) begin
               if (bank_we[b]) mem[int'(bank_row[b*RW +: RW]) * NB + b] <= bank_wdata;
               else begin
                  dl_v[0] <= 1'b1;
                  dl_b[0] <= LB'(b);
                  dl_d[0] <= mem[int'(bank_row[b*RW +: RW]) * NB + b];
               end
            end
         end
      end
   end

   always_comb begin
      bank_rdata = '0;
      if (dl_v[LAT-1]) bank_rdata[dl_b[LAT-1]*DW +: DW] = dl_d[LAT-1];
   end

   // scoreboard
   typedef struct {
      logic [AW-1:0] a;
      bit            we;
      logic [DW-1:0] wd;
      int            idx;
      bit            last;
   } acc_t;
   typedef struct {
      int            idx;
      logic [DW-1:0] d;
      bit            last;
      longint        c;
   } ld_t;

   acc_t   acc_q[$];
   ld_t    ld_q[$];
   string  cur_tag  = "R0";
   string  done_tag = "R10";
   int     cur_cnt  = 0;
   bit     mon_on   = 0;
   bit     busy_f   = 0;
   longint prev_cyc = 0;
   longint exp_done = -1;
   longint last_acc [NB];
   int     mb, ma, eb;
   longint ec;

   initial for (int b = 0; b < NB; b++) last_acc[b] = -1000;

   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         chk(req_ready == !busy_f, "R2", "req_ready", req_ready, !busy_f);
         if (req_valid && req_ready) begin
            prev_cyc = cyc;
            busy_f   = 1;
            if (cur_cnt == 0) exp_done = cyc + 1;
         end
         if (bank_en != '0) begin
            chk($countones(bank_en) == 1, "R3", "enable count", $countones(bank_en), 1);
            mb = 0;
            for (int b = 0; b < NB; b++) if (bank_en[b]) mb = b;
            ma = int'(bank_row[mb*RW +: RW]) * NB + mb;
            if (acc_q.size() == 0) begin
               chk(0, cur_tag, "unexpected bank access", ma, -1);
            end else begin
               acc_t e;
               e  = acc_q.pop_front();
               eb = int'(e.a) % NB;
               chk(ma == int'(e.a), cur_tag, "element address", ma, e.a);
               ec = lmax(prev_cyc + 1, last_acc[eb] + BUSY);
               chk(cyc == ec, cur_tag, "issue cycle", cyc, ec);
               prev_cyc     = cyc;
               last_acc[eb] = cyc;
               chk(bank_we[mb] == e.we, "R9", "write enable", bank_we[mb], e.we);
               if (e.we) begin
                  chk(bank_wdata == e.wd, "R9", "write data", bank_wdata, e.wd);
                  shadow[e.a] = e.wd;
                  if (e.last) exp_done = cyc + 1;
               end else begin
                  ld_q.push_back('{idx: e.idx, d: shadow[e.a], last: e.last, c: cyc + LAT});
               end
            end
         end
         if (ld_valid) begin
            if (ld_q.size() == 0) begin
               chk(0, "R9", "unexpected load data", ld_idx, -1);
            end else begin
               ld_t x;
               x = ld_q.pop_front();
               chk(int'(ld_idx) == x.idx, "R8", "element index", ld_idx, x.idx);
               chk(ld_data == x.d, cur_tag, "load data", ld_data, x.d);
               chk(ld_last == x.last, "R8", "last flag", ld_last, x.last);
               chk(cyc == x.c, "R8", "return cycle", cyc, x.c);
               if (x.last) exp_done = cyc + 1;
            end
         end
         if (done) begin
            chk(cyc == exp_done, done_tag, "done cycle", cyc, exp_done);
            busy_f = 0;
         end
      end
   end

   int iv [MAXN];
   int wv [MAXN];

   task automatic run_req(input string tag, input bit st, input bit ix,
                          input int base, input int stride, input int cnt);
      acc_t e;
      int   a;
      cur_tag  = tag;
      cur_cnt  = cnt;
      done_tag = (cnt == 0) ? "R12" : "R10";
      for (int i = 0; i < cnt; i++) begin
         a      = ix ? (base + iv[i]) : (base + i * stride);
         a      = a & (WORDS - 1);
         e.a    = AW'(a);
         e.we   = st;
         e.wd   = wv[i][DW-1:0];
         e.idx  = i;
         e.last = (i == cnt - 1);
         acc_q.push_back(e);
      end
      for (int i = 0; i < MAXN; i++) begin
         req_index[i*AW +: AW] = iv[i][AW-1:0];
         req_wdata[i*DW +: DW] = wv[i][DW-1:0];
      end
      req_base    = base[AW-1:0];
      req_stride  = stride[AW-1:0];
      req_count   = cnt[CW-1:0];
      req_store   = st;
      req_indexed = ix;
      req_valid   = 1'b1;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #1;
      req_valid = 1'b0;
      do @(negedge clk); while (!done);
      @(posedge clk); #1;
      chk(acc_q.size() == 0, tag, "accesses left over", acc_q.size(), 0);
      chk(ld_q.size() == 0, tag, "loads left over", ld_q.size(), 0);
   endtask

   task automatic fill(input int kind);
      for (int i = 0; i < MAXN; i++) begin
         iv[i] = 0;
         wv[i] = (kind + 1) * 1000 + i * 111 + 7;
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_indexed = 1'b0;
      req_base = '0; req_stride = '0; req_count = '0; req_index = '0; req_wdata = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
      chk(bank_en == '0, "R1", "bank_en after reset", bank_en, 0);
      chk(ld_valid == 1'b0, "R1", "ld_valid after reset", ld_valid, 0);
      chk(done == 1'b0, "R1", "done after reset", done, 0);
      mon_on = 1;
      @(posedge clk); #1;

      fill(0); run_req("R7", 0, 0, 'h040, 1, 16);    // unit stride, full rate
      fill(0); run_req("R4", 0, 0, 'h100, 3, 12);    // stride coprime to banks
      fill(0); run_req("R4", 0, 0, 'h3FC, 3, 4);     // wraps past top of space
      fill(0); run_req("R4", 0, 0, 'h010, -5, 6);    // negative stride
      fill(0); run_req("R6", 0, 0, 'h021, 8, 5);     // all on one bank
      fill(0); run_req("R6", 0, 0, 'h0A0, 4, 6);     // two banks alternating
      fill(1); run_req("R9", 1, 0, 'h200, 5, 10);    // strided store
      fill(1); run_req("R9", 0, 0, 'h200, 5, 10);    // read it back
      fill(2);
      iv[0] = 5; iv[1] = 13; iv[2] = 2; iv[3] = 21; iv[4] = 0; iv[5] = 8; iv[6] = 100; iv[7] = 999;
      run_req("R5", 0, 1, 'h080, 0, 8);              // gather with repeated banks
      fill(3);
      iv[0] = 3; iv[1] = 11; iv[2] = 40; iv[3] = 7;
      run_req("R5", 1, 1, 'h300, 0, 4);              // scatter
      run_req("R5", 0, 1, 'h300, 0, 4);              // gather back
      fill(0); run_req("R11", 0, 0, 'h055, 0, 4);    // zero stride
      fill(0); run_req("R12", 0, 0, 'h000, 1, 0);    // empty request
      fill(4); run_req("R13", 1, 0, 'h070, 1, 1);    // leaves bank 0 busy
      fill(4); run_req("R13", 0, 0, 'h078, 1, 1);    // same bank right after
      fill(0); run_req("R8", 0, 0, 'h070, 1, 1);     // single element, last flag

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule